// File: doc/BRIEF.md
# Windowed Address Translation Registers

This block rewrites addresses leaving a local bus so that they land in the right place on a remote bus. The local side is carved into a build-time number of address windows. Each window has a substitution value that replaces the upper part of the local address, while the lower part, whose width is set by that window's size, is copied straight through. A separate window decoder supplies a hit flag and the index of the window that was hit. The block registers the translated address and a valid flag one cycle later.

Software programs the substitution values through a small word-addressed register port. A build option chooses between run-time registers and fixed per-window constants. The same register port also holds a control word that carries the local bus number and the highest subordinate bus number. Both fields are exported as output pins.

Bit positions below use the usual convention, so bit 31 is the most significant. In the alternative convention where bit 0 is the most significant, the bus number field is bits 8 to 15 and the subordinate field is bits 24 to 31.

Top module: `addr_xlate_windows`

## Requirements
- R1: The register map is word-addressed. Byte offset 0x00 is the control word, and byte offset 4*(n+1) is the translation register of window n. Any other offset, and any offset with reg_addr[1:0] not zero, reads as zero and ignores writes, leaving every register unchanged.
- R2: Window n keeps only 32-LOW_n bits, where LOW_n is that window's low-bit count (defaults 12, 16, 20 and 24 for windows 0 to 3). A hit on window n yields rem_addr[31:LOW_n] equal to the stored bits and rem_addr[LOW_n-1:0] equal to loc_addr[LOW_n-1:0].
- R3: A translation register reads back as a full 32-bit word. Bits [31:LOW_n] hold the stored value, and bits [LOW_n-1:0] read as zero whatever was written to them.
- R4: A synchronous active-low reset clears every translation register, the control word, reg_rdata and rem_vld to zero.
- R5: A register write changes translations sampled from the next clock edge on. A translation sampled on the same edge as the write still uses the old value.
- R6: rem_addr and rem_vld are registered and reflect loc_addr, win_hit_vld and win_hit_idx from the previous clock edge. rem_vld is 1 on a hit.
- R7: When win_hit_vld is 0, rem_addr equals the previous loc_addr unchanged and rem_vld is 0.
- R8: With USE_REGS = 0, the per-window constant XLATE_CONST[n] supplies bits [31:LOW_n] of the translation. The window offsets then read as zero, and writes to them have no effect on translation.
- R9: In the control word, bits [23:16] hold the bus number and bits [7:0] hold the highest subordinate bus number, and these are driven on bus_num and sub_bus_num. All other bits read as zero and ignore writes.
- R10: reg_rdata is valid in the cycle after reg_rd_en is sampled high. It is zero after any clock edge where reg_rd_en was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | RA_W (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| bus_num | output | 8 | Programmed bus number |
| sub_bus_num | output | 8 | Programmed highest subordinate bus number |
| loc_addr | input | 32 | Local address to translate |
| win_hit_vld | input | 1 | A window was hit |
| win_hit_idx | input | IDX_W (2) | Index of the window that was hit |
| rem_addr | output | 32 | Translated remote address |
| rem_vld | output | 1 | Translation came from a window hit |

## Verification
The hardest case to reach is a register write that lands on the same clock edge as a translation through the same window. There, the old substitution value must still appear, and the new one must appear one cycle later. The bench drives a window write and a hit on that window in the same cycle, then keeps the hit steady and samples two consecutive cycles. Fixed-constant mode is covered by a second instance built with USE_REGS = 0 on the shared register bus, so writes aimed at the first instance also show that they do not affect the second.

// File: rtl/axw_pkg.sv
// Shared types and helpers for the windowed address translator.
// Assumes a 32-bit register word and word-aligned register offsets.
package axw_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Mask that covers the pass-through (low) bits of a window
    function automatic word_t low_mask(input int unsigned low_bits);
        word_t m;
        m = '0;
        for (int unsigned b = 0; b < WORD_W; b++) begin
            if (b < low_bits) m[b] = 1'b1;
        end
        return m;
    endfunction

    // Register word index for the translation register of window n
    function automatic int unsigned win_word_idx(input int unsigned n);
        return n + 1;
    endfunction

endpackage

// File: rtl/axw_busnum_reg.sv
// Control word holding the bus number and highest subordinate bus number.
// Assumes the parent has already decoded the write select for word 0.
module axw_busnum_reg
    import axw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sel,
    input  logic [7:0] bus_d,
    input  logic [7:0] sub_d,
    output logic [7:0] bus_q,
    output logic [7:0] sub_q,
    output word_t      word_o
);

    // Store both 8-bit fields on a selected write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '0;
            sub_q <= '0;
        end else if (wr_sel) begin
            bus_q <= bus_d;
            sub_q <= sub_d;
        end
    end

    // Reserved byte lanes read as zero
    always_comb begin
        word_o = {8'h00, bus_q, 8'h00, sub_q};
    end

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> ($stable(bus_q) && $stable(sub_q)));

    // R9
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (bus_q == $past(bus_d) && sub_q == $past(sub_d)));

endmodule

// File: rtl/axw_win_slot.sv
// One translation window: holds the high-order substitution bits.
// USE_REGS picks a run-time register or a fixed build-time constant.
// Assumes 0 < LOW_BITS < 32 so that at least one bit is substituted.
module axw_win_slot
    import axw_pkg::*;
#(
    parameter int unsigned LOW_BITS = 12,
    parameter bit          USE_REGS = 1'b1,
    parameter word_t       FIXED    = '0,
    localparam int unsigned HI_W    = WORD_W - LOW_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic [HI_W-1:0] wdata_hi,
    output word_t           xl_o,
    output word_t           rd_o
);

    if (USE_REGS) begin : g_reg
        logic [HI_W-1:0] hi_q;

        // Hold only the implemented high-order bits
        always_ff @(posedge clk) begin
            if (!rst_n) hi_q <= '0;
            else if (wr_sel) hi_q <= wdata_hi;
        end

        // Expand to a full word with the low positions tied to zero
        always_comb begin
            xl_o = {hi_q, {LOW_BITS{1'b0}}};
            rd_o = xl_o;
        end

        // R5
        win_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel |=> hi_q == $past(wdata_hi));

        // R1
        win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel |=> $stable(hi_q));
    end else begin : g_const
        // Constant substitution bits; the register offset is unmapped
        always_comb begin
            xl_o = FIXED & ~low_mask(LOW_BITS);
            rd_o = '0;
        end
    end

endmodule

// File: rtl/axw_rd_port.sv
// Register read path: selects a word and registers it one cycle later.
// Assumes the parent supplies the decoded word index and alignment.
module axw_rd_port
    import axw_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned WI_W    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            aligned,
    input  logic [WI_W-1:0] word_idx,
    input  word_t           ctrl_word,
    input  word_t           win_word [NUM_WIN],
    output word_t           rdata
);

    word_t rd_val;

    // Choose the addressed word; unmapped or misaligned gives zero
    always_comb begin
        rd_val = '0;
        if (word_idx == '0) rd_val = ctrl_word;
        for (int unsigned n = 0; n < NUM_WIN; n++) begin
            if (word_idx == WI_W'(win_word_idx(n))) rd_val = win_word[n];
        end
        if (!aligned) rd_val = '0;
    end

    // Present the data one cycle after the strobe, else zero
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else rdata <= rd_en ? rd_val : '0;
    end

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

    // R1
    rd_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !aligned) |=> rdata == '0);

endmodule

// File: rtl/axw_xlate.sv
// Translation stage: substitutes the hit window's high bits and
// registers the result. Assumes the window words have zero low bits.
module axw_xlate
    import axw_pkg::*;
#(
    parameter int unsigned NUM_WIN  = 4,
    parameter int unsigned IDX_W    = 2,
    parameter int unsigned WIN_LOW_BITS [NUM_WIN] = '{12, 16, 20, 24}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  word_t            loc_addr,
    input  logic             hit_vld,
    input  logic [IDX_W-1:0] hit_idx,
    input  word_t            win_word [NUM_WIN],
    output word_t            rem_addr,
    output logic             rem_vld
);

    word_t sel_word;
    word_t sel_mask;
    logic  hit_ok;
    word_t rem_nxt;

    // Look up the hit window's substitution word and low mask
    always_comb begin
        sel_word = '0;
        sel_mask = '1;
        hit_ok   = 1'b0;
        for (int unsigned n = 0; n < NUM_WIN; n++) begin
            if (int'(hit_idx) == int'(n)) begin
                sel_word = win_word[n];
                sel_mask = low_mask(WIN_LOW_BITS[n]);
                hit_ok   = hit_vld;
            end
        end
        if (!hit_ok) sel_mask = '1;
        rem_nxt = (sel_word & ~sel_mask) | (loc_addr & sel_mask);
    end

    // Register the translated address and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_addr <= '0;
            rem_vld  <= 1'b0;
        end else begin
            rem_addr <= rem_nxt;
            rem_vld  <= hit_ok;
        end
    end

    // R7
    miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vld |=> (!rem_vld && rem_addr == $past(loc_addr)));

    // R2
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> ((rem_addr ^ $past(loc_addr)) & $past(sel_mask)) == '0);

    // R6
    hit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> rem_vld);

endmodule

// File: rtl/addr_xlate_windows.sv
// Top of the windowed address translator. Decodes the register port,
// instantiates one slot per window, the control word, the read path
// and the translation stage. Assumes word-aligned register offsets.
module addr_xlate_windows
    import axw_pkg::*;
#(
    parameter int unsigned NUM_WIN  = 4,
    parameter int unsigned RA_W     = 8,
    parameter bit          USE_REGS = 1'b1,
    parameter int unsigned WIN_LOW_BITS [NUM_WIN] = '{12, 16, 20, 24},
    parameter word_t       XLATE_CONST [NUM_WIN] =
        '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [7:0]       bus_num,
    output logic [7:0]       sub_bus_num,
    input  logic [31:0]      loc_addr,
    input  logic             win_hit_vld,
    input  logic [IDX_W-1:0] win_hit_idx,
    output logic [31:0]      rem_addr,
    output logic             rem_vld
);

    localparam int unsigned WI_W = RA_W - 2;

    logic            aligned;
    logic [WI_W-1:0] word_idx;
    logic            ctrl_wr;
    word_t           ctrl_word;
    word_t           win_xl [NUM_WIN];
    word_t           win_rd [NUM_WIN];

    // Split the byte offset into word index and alignment
    always_comb begin
        aligned  = (reg_addr[1:0] == 2'b00);
        word_idx = reg_addr[RA_W-1:2];
        ctrl_wr  = reg_wr_en && aligned && (word_idx == '0);
    end

    axw_busnum_reg i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (ctrl_wr),
        .bus_d  (reg_wdata[23:16]),
        .sub_d  (reg_wdata[7:0]),
        .bus_q  (bus_num),
        .sub_q  (sub_bus_num),
        .word_o (ctrl_word)
    );

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        localparam int unsigned LB = WIN_LOW_BITS[n];
        logic slot_wr;

        // Decode the write select for this window's offset
        always_comb begin
            slot_wr = reg_wr_en && aligned &&
                      (word_idx == WI_W'(win_word_idx(n)));
        end

        axw_win_slot #(
            .LOW_BITS (LB),
            .USE_REGS (USE_REGS),
            .FIXED    (XLATE_CONST[n])
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (slot_wr),
            .wdata_hi (reg_wdata[31:LB]),
            .xl_o     (win_xl[n]),
            .rd_o     (win_rd[n])
        );
    end

    axw_rd_port #(
        .NUM_WIN (NUM_WIN),
        .WI_W    (WI_W)
    ) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (reg_rd_en),
        .aligned   (aligned),
        .word_idx  (word_idx),
        .ctrl_word (ctrl_word),
        .win_word  (win_rd),
        .rdata     (reg_rdata)
    );

    axw_xlate #(
        .NUM_WIN      (NUM_WIN),
        .IDX_W        (IDX_W),
        .WIN_LOW_BITS (WIN_LOW_BITS)
    ) i_xl (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_addr (loc_addr),
        .hit_vld  (win_hit_vld),
        .hit_idx  (win_hit_idx),
        .win_word (win_xl),
        .rem_addr (rem_addr),
        .rem_vld  (rem_vld)
    );

    // R4
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rem_vld && reg_rdata == '0 && bus_num == '0));

endmodule

// File: tb/test_addr_xlate_windows.sv
module test_addr_xlate_windows;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] loc_addr = '0;
    logic        win_hit_vld = 1'b0;
    logic [1:0]  win_hit_idx = '0;

    logic [31:0] reg_rdata, rem_addr, f_rdata, f_rem_addr;
    logic [7:0]  bus_num, sub_bus_num, f_bus, f_sub;
    logic        rem_vld, f_rem_vld;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    addr_xlate_windows i_addr_xlate_windows (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_num(bus_num), .sub_bus_num(sub_bus_num), .loc_addr(loc_addr),
        .win_hit_vld(win_hit_vld), .win_hit_idx(win_hit_idx),
        .rem_addr(rem_addr), .rem_vld(rem_vld)
    );

    addr_xlate_windows #(
        .USE_REGS    (1'b0),
        .XLATE_CONST ('{32'h8000_0ABC, 32'h4444_5555, 32'h0123_4567, 32'hFF00_FF00})
    ) i_addr_xlate_windows_fixed (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(f_rdata),
        .bus_num(f_bus), .sub_bus_num(f_sub), .loc_addr(loc_addr),
        .win_hit_vld(win_hit_vld), .win_hit_idx(win_hit_idx),
        .rem_addr(f_rem_addr), .rem_vld(f_rem_vld)
    );

    // {hit, idx, loc_addr, expected rem_addr, expected rem_vld}
    localparam int NVEC = 8;
    localparam logic [67:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 32'h0000_0123, 32'hA5A5_5123, 1'b1},
        {1'b1, 2'd0, 32'hFFFF_FFFF, 32'hA5A5_5FFF, 1'b1},
        {1'b1, 2'd1, 32'h89AB_CDEF, 32'h1234_CDEF, 1'b1},
        {1'b1, 2'd2, 32'h0013_5555, 32'hCAF3_5555, 1'b1},
        {1'b1, 2'd3, 32'h0F00_0001, 32'h7E00_0001, 1'b1},
        {1'b1, 2'd3, 32'hFFFF_FFFF, 32'h7EFF_FFFF, 1'b1},
        {1'b0, 2'd2, 32'h1357_9BDF, 32'h1357_9BDF, 1'b0},
        {1'b1, 2'd1, 32'h0000_0000, 32'h1234_0000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a);
        reg_rd_en = 1'b1;
        reg_addr  = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R4: reset state
        check("R4 rem_vld", {31'b0, rem_vld}, 32'h0);
        check("R4 rdata", reg_rdata, 32'h0);
        check("R4 bus_num", {24'b0, bus_num}, 32'h0);
        reg_read(8'h00);
        check("R4 ctrl read", reg_rdata, 32'h0);
        reg_read(8'h04);
        check("R4 win0 read", reg_rdata, 32'h0);
        reg_read(8'h10);
        check("R4 win3 read", reg_rdata, 32'h0);

        // R3: program windows, low bits read back zero
        reg_write(8'h04, 32'hA5A5_5FFF);
        reg_write(8'h08, 32'h1234_ABCD);
        reg_write(8'h0C, 32'hCAFE_F00D);
        reg_write(8'h10, 32'h7E11_2233);
        reg_read(8'h04); check("R3 win0", reg_rdata, 32'hA5A5_5000);
        reg_read(8'h08); check("R3 win1", reg_rdata, 32'h1234_0000);
        reg_read(8'h0C); check("R3 win2", reg_rdata, 32'hCAF0_0000);
        reg_read(8'h10); check("R3 win3", reg_rdata, 32'h7E00_0000);

        // R2, R6, R7: vector table
        for (int i = 0; i < NVEC; i++) begin
            win_hit_vld = VEC[i][67];
            win_hit_idx = VEC[i][66:65];
            loc_addr    = VEC[i][64:33];
            @(negedge clk);
            check("R2/R7 rem_addr", rem_addr, VEC[i][32:1]);
            check("R6 rem_vld", {31'b0, rem_vld}, {31'b0, VEC[i][0]});
        end
        win_hit_vld = 1'b0;

        // R9: control word fields
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00);
        check("R9 ctrl ones", reg_rdata, 32'h00FF_00FF);
        reg_write(8'h00, 32'h1234_5678);
        reg_read(8'h00);
        check("R9 ctrl value", reg_rdata, 32'h0034_0078);
        check("R9 bus_num pin", {24'b0, bus_num}, 32'h34);
        check("R9 sub_bus_num pin", {24'b0, sub_bus_num}, 32'h78);

        // R10: no read strobe gives zero
        @(negedge clk);
        check("R10 idle rdata", reg_rdata, 32'h0);

        // R1: unmapped and misaligned offsets
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_write(8'h09, 32'hFFFF_FFFF);
        reg_read(8'h40); check("R1 unmapped read", reg_rdata, 32'h0);
        reg_read(8'h05); check("R1 misaligned read", reg_rdata, 32'h0);
        reg_read(8'h08); check("R1 win1 untouched", reg_rdata, 32'h1234_0000);
        reg_read(8'h00); check("R1 ctrl untouched", reg_rdata, 32'h0034_0078);

        // R5: write and translation on the same edge
        win_hit_vld = 1'b1;
        win_hit_idx = 2'd0;
        loc_addr    = 32'h0000_0777;
        reg_write(8'h04, 32'h0F0F_0ABC);
        check("R5 old value", rem_addr, 32'hA5A5_5777);
        @(negedge clk);
        check("R5 new value", rem_addr, 32'h0F0F_0777);

        // R8: fixed-constant instance ignores window registers
        check("R8 fixed win0", f_rem_addr, 32'h8000_0777);
        win_hit_idx = 2'd3;
        loc_addr    = 32'h00AB_CDEF;
        @(negedge clk);
        check("R8 fixed win3", f_rem_addr, 32'hFFAB_CDEF);
        reg_read(8'h04);
        check("R8 fixed window read", f_rdata, 32'h0);
        win_hit_vld = 1'b0;

        summary();
    end

endmodule